// File: doc/BRIEF.md
# Dual-Clock FIFO with Spill Recovery

This block moves a byte stream from a write clock domain into a transmit (read) clock domain through a small dual-clock FIFO. The two pointers cross domains as Gray code through two-flop synchronizers. On the read side, a clock enable requests one word per enabled cycle. A spill detector flags two faults: an overflow, which is a write attempted while the FIFO is full, and an underflow, which is a read attempted while it is empty. Both faults are reported in the transmit domain.

Each new spill raises a one-cycle pulse and sets a sticky status bit. Software clears that bit with a write-one pulse. A mask bit keeps the status bit from reaching the interrupt output.

An automatic recovery policy can also act on each new spill. Depending on a selector bit, it either asks the upstream aligner for a fresh frame alignment, or it recenters the FIFO locally by moving the read pointer to half a depth behind the synchronized write pointer. The policy can be made to act only while a lock indication is high. A source bit picks that lock indication: the phase-lock signal for synchronous mapping or the rate-lock signal for asynchronous mapping.

Top module: `cdc_spill_fifo`

## Requirements
- R1: Words written on `wr_clk` come out on `rd_data` in write order. `rd_valid` is high for one `rd_clk` cycle, in the cycle after an enabled cycle that found the FIFO non-empty.
- R2: The FIFO holds exactly DEPTH (default 16) words. A write attempted while full is dropped, and it raises a spill.
- R3: An enabled read cycle that finds the FIFO empty returns no word (`rd_valid` stays 0) and raises a spill.
- R4: `spill_pulse` is one `rd_clk` cycle wide. It fires once per rise of the spill condition, and it does not repeat while the condition is held.
- R5: `spill_status` is set by each spill and stays set until a `spill_clr` pulse clears it. If a set and a clear arrive in the same cycle, the set wins.
- R6: `spill_irq` equals `spill_status` AND NOT `cfg_irq_mask`.
- R7: With `cfg_auto_recover`=0, a spill produces neither `realign_req` nor `ptr_reset`.
- R8: With `cfg_auto_recover`=1 and `cfg_realign_sel`=1, each new spill issues a one-cycle `realign_req` and no `ptr_reset`.
- R9: With `cfg_auto_recover`=1 and `cfg_realign_sel`=0, each new spill issues a one-cycle `ptr_reset` and no `realign_req`. The reset recenters the FIFO, so exactly DEPTH/2 words become readable and the pending underflow is cleared.
- R10: With `cfg_lock_qual`=1, recovery acts only while the selected lock input is high. `cfg_lock_src`=0 selects `lock_pll` and `cfg_lock_src`=1 selects `lock_rll`. With `cfg_lock_qual`=0, the lock inputs are ignored.
- R11: After reset, `rd_valid`, `spill_pulse`, `spill_status`, `spill_irq`, `realign_req` and `ptr_reset` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Write-domain clock |
| wr_rst_n | input | 1 | Write-domain active-low reset |
| wr_en | input | 1 | Write request |
| wr_data | input | DATA_W | Word to write |
| rd_clk | input | 1 | Transmit-domain clock |
| rd_rst_n | input | 1 | Transmit-domain active-low reset |
| rd_clken | input | 1 | Read clock enable, one word per enabled cycle |
| rd_data | output | DATA_W | Word read |
| rd_valid | output | 1 | rd_data holds a word |
| lock_pll | input | 1 | Phase-lock indication (synchronous mapping) |
| lock_rll | input | 1 | Rate-lock indication (asynchronous mapping) |
| cfg_lock_src | input | 1 | 0: use lock_pll, 1: use lock_rll |
| cfg_auto_recover | input | 1 | Enable automatic recovery on spill |
| cfg_realign_sel | input | 1 | 1: realignment request, 0: pointer reset |
| cfg_lock_qual | input | 1 | Require lock before recovery acts |
| cfg_irq_mask | input | 1 | Masks the spill interrupt |
| spill_clr | input | 1 | Write-one-to-clear pulse for spill_status |
| spill_pulse | output | 1 | One-cycle pulse per new spill |
| spill_status | output | 1 | Sticky spill indication |
| spill_irq | output | 1 | Spill interrupt |
| realign_req | output | 1 | Upstream new-frame-alignment request pulse |
| ptr_reset | output | 1 | Local FIFO pointer reset pulse |

## Verification
A pointer that drifts or a Gray value that decodes wrongly shows up at `rd_data` as a word out of order or a repeated word. It can also show up as a `rd_valid` with no word pending, within a few read cycles of the fault. A spill edge detector stuck high or stuck low changes how many `spill_pulse`, `realign_req` or `ptr_reset` pulses appear per provoked fault, and that difference is visible within three transmit cycles of the fault. A recentering error changes the number of words readable after `ptr_reset`, so draining the FIFO right after the reset exposes it.

// File: rtl/cdc_fifo_pkg.sv
package cdc_fifo_pkg;

  typedef enum logic [1:0] {
    ACT_NONE    = 2'd0,
    ACT_REALIGN = 2'd1,
    ACT_PRST    = 2'd2
  } spill_act_e;

  // Chooses which lock indication qualifies the recovery policy.
  function automatic logic pick_lock(input logic src_async, input logic pll, input logic rll);
    return src_async ? rll : pll;
  endfunction

  // Recovery decision for one new spill.
  function automatic spill_act_e pick_action(input logic auto_en, input logic realign_sel,
                                             input logic lock_qual, input logic lock_ok);
    if (!auto_en) return ACT_NONE;
    if (lock_qual && !lock_ok) return ACT_NONE;
    return realign_sel ? ACT_REALIGN : ACT_PRST;
  endfunction

endpackage

// File: rtl/cdc_sync.sv
module cdc_sync #(
  parameter int W = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta <= '0;
      q    <= '0;
    end else begin
      meta <= d;
      q    <= meta;
    end
  end
endmodule

// File: rtl/fifo_wr_ctl.sv
module fifo_wr_ctl #(
  parameter int AW = 4
) (
  input  logic          wr_clk,
  input  logic          wr_rst_n,
  input  logic          wr_en,
  input  logic [AW:0]   rd_gray_s,
  output logic [AW-1:0] wr_addr,
  output logic          wr_push,
  output logic [AW:0]   wr_gray,
  output logic          ovf_flag
);
  localparam logic [AW:0] DEPTH_P = (AW+1)'(1) << AW;

  function automatic logic [AW:0] gray_to_bin(input logic [AW:0] g);
    logic [AW:0] b;
    b[AW] = g[AW];
    for (int i = AW - 1; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

  function automatic logic [AW:0] bin_to_gray(input logic [AW:0] b);
    return b ^ (b >> 1);
  endfunction

  logic [AW:0] wr_bin;
  logic [AW:0] fill_w;
  logic        wr_full;
  logic        ovf_evt;
  logic [AW:0] wr_bin_nx;

  assign fill_w    = wr_bin - gray_to_bin(rd_gray_s);
  assign wr_full   = (fill_w >= DEPTH_P);
  assign wr_push   = wr_en && !wr_full;
  assign ovf_evt   = wr_en && wr_full;
  assign wr_addr   = wr_bin[AW-1:0];
  assign wr_bin_nx = wr_bin + (AW+1)'(wr_push);

  always_ff @(posedge wr_clk or negedge wr_rst_n) begin
    if (!wr_rst_n) begin
      wr_bin   <= '0;
      wr_gray  <= '0;
      ovf_flag <= 1'b0;
    end else begin
      wr_bin  <= wr_bin_nx;
      wr_gray <= bin_to_gray(wr_bin_nx);
      if (ovf_evt)      ovf_flag <= 1'b1;
      else if (wr_push) ovf_flag <= 1'b0;
    end
  end

  // R2
  ovf_needs_write_chk: assert property (@(posedge wr_clk) disable iff (!wr_rst_n)
    $rose(ovf_flag) |-> $past(wr_en));
endmodule

// File: rtl/fifo_rd_ctl.sv
module fifo_rd_ctl #(
  parameter int AW = 4
) (
  input  logic          rd_clk,
  input  logic          rd_rst_n,
  input  logic          rd_clken,
  input  logic [AW:0]   wr_gray_s,
  input  logic          prst,
  output logic [AW-1:0] rd_addr,
  output logic          rd_pop,
  output logic [AW:0]   rd_gray,
  output logic          udf_flag
);
  localparam logic [AW:0] DEPTH_P = (AW+1)'(1) << AW;
  localparam logic [AW:0] HALF_P  = DEPTH_P >> 1;

  function automatic logic [AW:0] gray_to_bin(input logic [AW:0] g);
    logic [AW:0] b;
    b[AW] = g[AW];
    for (int i = AW - 1; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

  function automatic logic [AW:0] bin_to_gray(input logic [AW:0] b);
    return b ^ (b >> 1);
  endfunction

  logic [AW:0] rd_bin;
  logic [AW:0] wr_bin_s;
  logic [AW:0] fill_r;
  logic        rd_empty;
  logic        udf_evt;
  logic [AW:0] rd_bin_nx;

  assign wr_bin_s = gray_to_bin(wr_gray_s);
  assign fill_r   = wr_bin_s - rd_bin;
  assign rd_empty = (fill_r == '0) || (fill_r > DEPTH_P);
  assign rd_pop   = rd_clken && !rd_empty && !prst;
  assign udf_evt  = rd_clken && rd_empty && !prst;
  assign rd_addr  = rd_bin[AW-1:0];

  always_comb begin
    if (prst)        rd_bin_nx = wr_bin_s - HALF_P;
    else if (rd_pop) rd_bin_nx = rd_bin + 1'b1;
    else             rd_bin_nx = rd_bin;
  end

  always_ff @(posedge rd_clk or negedge rd_rst_n) begin
    if (!rd_rst_n) begin
      rd_bin   <= '0;
      rd_gray  <= '0;
      udf_flag <= 1'b0;
    end else begin
      rd_bin  <= rd_bin_nx;
      rd_gray <= bin_to_gray(rd_bin_nx);
      if (prst)         udf_flag <= 1'b0;
      else if (udf_evt) udf_flag <= 1'b1;
      else if (rd_pop)  udf_flag <= 1'b0;
    end
  end

  // R3
  udf_needs_read_chk: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
    $rose(udf_flag) |-> $past(rd_clken));

  // R9
  prst_clears_udf_chk: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
    prst |=> !udf_flag);
endmodule

// File: rtl/spill_policy.sv
module spill_policy
  import cdc_fifo_pkg::*;
(
  input  logic rd_clk,
  input  logic rd_rst_n,
  input  logic ovf_lvl,
  input  logic udf_flag,
  input  logic lock_pll,
  input  logic lock_rll,
  input  logic cfg_lock_src,
  input  logic cfg_auto_recover,
  input  logic cfg_realign_sel,
  input  logic cfg_lock_qual,
  input  logic cfg_irq_mask,
  input  logic spill_clr,
  output logic spill_pulse,
  output logic spill_status,
  output logic spill_irq,
  output logic realign_req,
  output logic prst_req
);
  logic       spill_cond;
  logic       spill_cond_q;
  logic       spill_evt;
  logic       lock_ok;
  spill_act_e act;

  assign spill_cond = ovf_lvl | udf_flag;
  assign spill_evt  = spill_cond && !spill_cond_q;
  assign lock_ok    = pick_lock(cfg_lock_src, lock_pll, lock_rll);
  assign act        = pick_action(cfg_auto_recover, cfg_realign_sel, cfg_lock_qual, lock_ok);
  assign spill_irq  = spill_status && !cfg_irq_mask;

  always_ff @(posedge rd_clk or negedge rd_rst_n) begin
    if (!rd_rst_n) begin
      spill_cond_q <= 1'b0;
      spill_pulse  <= 1'b0;
      spill_status <= 1'b0;
      realign_req  <= 1'b0;
      prst_req     <= 1'b0;
    end else begin
      spill_cond_q <= spill_cond;
      spill_pulse  <= spill_evt;
      realign_req  <= spill_evt && (act == ACT_REALIGN);
      prst_req     <= spill_evt && (act == ACT_PRST);
      if (spill_evt)      spill_status <= 1'b1;
      else if (spill_clr) spill_status <= 1'b0;
    end
  end

  // R4
  pulse_single_chk: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
    spill_pulse |=> !spill_pulse);

  // R5
  status_sticky_chk: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
    (spill_status && !spill_clr) |=> spill_status);

  // R7
  req_exclusive_chk: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
    !(realign_req && prst_req));

  // R8
  realign_policy_chk: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
    realign_req |-> $past(cfg_auto_recover && cfg_realign_sel));

  // R9
  prst_policy_chk: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
    prst_req |-> $past(cfg_auto_recover && !cfg_realign_sel));
endmodule

// File: rtl/cdc_spill_fifo.sv
module cdc_spill_fifo #(
  parameter int DATA_W = 8,
  parameter int AW     = 4
) (
  input  logic              wr_clk,
  input  logic              wr_rst_n,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_clk,
  input  logic              rd_rst_n,
  input  logic              rd_clken,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_valid,
  input  logic              lock_pll,
  input  logic              lock_rll,
  input  logic              cfg_lock_src,
  input  logic              cfg_auto_recover,
  input  logic              cfg_realign_sel,
  input  logic              cfg_lock_qual,
  input  logic              cfg_irq_mask,
  input  logic              spill_clr,
  output logic              spill_pulse,
  output logic              spill_status,
  output logic              spill_irq,
  output logic              realign_req,
  output logic              ptr_reset
);
  localparam int DEPTH = 1 << AW;

  logic [DATA_W-1:0] mem [DEPTH];
  logic [AW-1:0]     wr_addr, rd_addr;
  logic              wr_push, rd_pop;
  logic [AW:0]       wr_gray, rd_gray, wr_gray_s, rd_gray_s;
  logic              ovf_flag, ovf_lvl, udf_flag;
  logic              prst_req;

  fifo_wr_ctl #(.AW(AW)) u_wr (
    .wr_clk(wr_clk), .wr_rst_n(wr_rst_n), .wr_en(wr_en), .rd_gray_s(rd_gray_s),
    .wr_addr(wr_addr), .wr_push(wr_push), .wr_gray(wr_gray), .ovf_flag(ovf_flag)
  );

  fifo_rd_ctl #(.AW(AW)) u_rd (
    .rd_clk(rd_clk), .rd_rst_n(rd_rst_n), .rd_clken(rd_clken), .wr_gray_s(wr_gray_s),
    .prst(prst_req), .rd_addr(rd_addr), .rd_pop(rd_pop), .rd_gray(rd_gray),
    .udf_flag(udf_flag)
  );

  cdc_sync #(.W(AW+1)) u_sync_w2r (
    .clk(rd_clk), .rst_n(rd_rst_n), .d(wr_gray), .q(wr_gray_s)
  );

  cdc_sync #(.W(AW+1)) u_sync_r2w (
    .clk(wr_clk), .rst_n(wr_rst_n), .d(rd_gray), .q(rd_gray_s)
  );

  cdc_sync #(.W(1)) u_sync_ovf (
    .clk(rd_clk), .rst_n(rd_rst_n), .d(ovf_flag), .q(ovf_lvl)
  );

  spill_policy u_pol (
    .rd_clk(rd_clk), .rd_rst_n(rd_rst_n), .ovf_lvl(ovf_lvl), .udf_flag(udf_flag),
    .lock_pll(lock_pll), .lock_rll(lock_rll), .cfg_lock_src(cfg_lock_src),
    .cfg_auto_recover(cfg_auto_recover), .cfg_realign_sel(cfg_realign_sel),
    .cfg_lock_qual(cfg_lock_qual), .cfg_irq_mask(cfg_irq_mask), .spill_clr(spill_clr),
    .spill_pulse(spill_pulse), .spill_status(spill_status), .spill_irq(spill_irq),
    .realign_req(realign_req), .prst_req(prst_req)
  );

  assign ptr_reset = prst_req;

  always_ff @(posedge wr_clk) begin
    if (wr_push) mem[wr_addr] <= wr_data;
  end

  always_ff @(posedge rd_clk or negedge rd_rst_n) begin
    if (!rd_rst_n) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_valid <= rd_pop;
      if (rd_pop) rd_data <= mem[rd_addr];
    end
  end

  // R1
  valid_after_enable_chk: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
    rd_valid |-> $past(rd_clken));
endmodule

// File: tb/cdc_spill_fifo_tb.sv
module cdc_spill_fifo_tb;
  logic       wr_clk = 0, rd_clk = 0;
  logic       wr_rst_n = 0, rd_rst_n = 0;
  logic       wr_en = 0;
  logic [7:0] wr_data = 0;
  logic       rd_clken = 0;
  logic [7:0] rd_data;
  logic       rd_valid;
  logic       lock_pll = 0, lock_rll = 0, cfg_lock_src = 0;
  logic       cfg_auto_recover = 0, cfg_realign_sel = 0, cfg_lock_qual = 0;
  logic       cfg_irq_mask = 0, spill_clr = 0;
  logic       spill_pulse, spill_status, spill_irq, realign_req, ptr_reset;

  always #2.5 rd_clk = ~rd_clk;
  always #3.5 wr_clk = ~wr_clk;

  cdc_spill_fifo u_dut (
    .wr_clk(wr_clk), .wr_rst_n(wr_rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .rd_clk(rd_clk), .rd_rst_n(rd_rst_n), .rd_clken(rd_clken),
    .rd_data(rd_data), .rd_valid(rd_valid),
    .lock_pll(lock_pll), .lock_rll(lock_rll), .cfg_lock_src(cfg_lock_src),
    .cfg_auto_recover(cfg_auto_recover), .cfg_realign_sel(cfg_realign_sel),
    .cfg_lock_qual(cfg_lock_qual), .cfg_irq_mask(cfg_irq_mask), .spill_clr(spill_clr),
    .spill_pulse(spill_pulse), .spill_status(spill_status), .spill_irq(spill_irq),
    .realign_req(realign_req), .ptr_reset(ptr_reset)
  );

  int checks = 0, failures = 0;
  int n_spill = 0, n_realign = 0, n_prst = 0, n_valid = 0;
  bit stale_mode = 0;
  bit done = 0;
  logic [7:0] model_q[$];
  logic [7:0] next_byte = 8'h10;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Reference model compared on every transmit clock.
  always @(negedge rd_clk) begin
    if (rd_rst_n) begin
      if (spill_pulse) n_spill++;
      if (realign_req) n_realign++;
      if (ptr_reset)   n_prst++;
      if (rd_valid) begin
        n_valid++;
        if (!stale_mode) begin
          if (model_q.size() == 0) begin
            check(0, "R1 word with empty model", int'(rd_data), -1);
          end else begin
            logic [7:0] e;
            e = model_q.pop_front();
            check(rd_data == e, "R1 data order", int'(rd_data), int'(e));
          end
        end
      end
    end
  end

  task automatic write_burst(input int n, input int keep);
    for (int i = 0; i < n; i++) begin
      @(negedge wr_clk);
      wr_en = 1;
      wr_data = next_byte;
      if (i < keep) model_q.push_back(next_byte);
      next_byte = next_byte + 8'd1;
    end
    @(negedge wr_clk);
    wr_en = 0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge rd_clk);
  endtask

  task automatic read_cycles(input int n);
    @(negedge rd_clk);
    rd_clken = 1;
    repeat (n) @(negedge rd_clk);
    rd_clken = 0;
  endtask

  // One good read followed by one read of an empty FIFO.
  task automatic underflow_once();
    write_burst(1, 1);
    idle(20);
    read_cycles(2);
    idle(12);
  endtask

  task automatic pulse_clr();
    @(negedge rd_clk);
    spill_clr = 1;
    @(negedge rd_clk);
    spill_clr = 0;
    idle(2);
  endtask

  initial begin
    int s0, r0, p0, v0;
    #2000000;
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    int s0, r0, p0, v0;
    idle(4);
    wr_rst_n = 1;
    rd_rst_n = 1;
    idle(3);
    // R11 reset state
    check(!rd_valid && !spill_pulse && !spill_status && !spill_irq && !realign_req && !ptr_reset,
          "R11 reset outputs", int'({rd_valid, spill_pulse, spill_status, spill_irq, realign_req, ptr_reset}), 0);

    // R1 plain transfer
    s0 = n_spill; v0 = n_valid;
    write_burst(10, 10);
    idle(20);
    read_cycles(10);
    idle(10);
    check(n_valid - v0 == 10, "R1 word count", n_valid - v0, 10);
    check(n_spill == s0, "R1 no spill", n_spill - s0, 0);
    check(model_q.size() == 0, "R1 model drained", model_q.size(), 0);

    // R3 / R7 underflow, reporting only
    s0 = n_spill; r0 = n_realign; p0 = n_prst; v0 = n_valid;
    underflow_once();
    check(n_valid - v0 == 1, "R3 only one word read", n_valid - v0, 1);
    check(n_spill - s0 == 1, "R3 spill on underflow", n_spill - s0, 1);
    check(n_realign == r0 && n_prst == p0, "R7 no recovery when disabled", n_realign - r0 + n_prst - p0, 0);
    check(spill_status == 1, "R5 status set", int'(spill_status), 1);
    check(spill_irq == 1, "R6 irq unmasked", int'(spill_irq), 1);

    // R4 held underflow gives one pulse
    s0 = n_spill; v0 = n_valid;
    write_burst(1, 1);
    idle(20);
    read_cycles(6);
    idle(10);
    check(n_valid - v0 == 1, "R4 one word", n_valid - v0, 1);
    check(n_spill - s0 == 1, "R4 single pulse while held", n_spill - s0, 1);

    // R5 clear
    pulse_clr();
    check(spill_status == 0, "R5 cleared by spill_clr", int'(spill_status), 0);
    check(spill_irq == 0, "R6 irq follows clear", int'(spill_irq), 0);

    // R6 mask
    @(negedge rd_clk); cfg_irq_mask = 1;
    underflow_once();
    check(spill_status == 1, "R6 status set under mask", int'(spill_status), 1);
    check(spill_irq == 0, "R6 irq masked", int'(spill_irq), 0);
    @(negedge rd_clk); cfg_irq_mask = 0;
    idle(1);
    check(spill_irq == 1, "R6 irq after unmask", int'(spill_irq), 1);
    pulse_clr();

    // R8 realignment
    @(negedge rd_clk); cfg_auto_recover = 1; cfg_realign_sel = 1; cfg_lock_qual = 0;
    r0 = n_realign; p0 = n_prst;
    underflow_once();
    check(n_realign - r0 == 1, "R8 realign issued", n_realign - r0, 1);
    check(n_prst == p0, "R8 no pointer reset", n_prst - p0, 0);

    // R10 lock qualification
    @(negedge rd_clk); cfg_lock_qual = 1; cfg_lock_src = 0; lock_pll = 0; lock_rll = 1;
    r0 = n_realign;
    underflow_once();
    check(n_realign == r0, "R10 blocked without pll lock", n_realign - r0, 0);
    @(negedge rd_clk); cfg_lock_src = 1;
    r0 = n_realign;
    underflow_once();
    check(n_realign - r0 == 1, "R10 rll lock selected", n_realign - r0, 1);
    @(negedge rd_clk); cfg_lock_src = 0; lock_pll = 1; lock_rll = 0;
    r0 = n_realign;
    underflow_once();
    check(n_realign - r0 == 1, "R10 pll lock selected", n_realign - r0, 1);
    @(negedge rd_clk); cfg_lock_qual = 0; lock_pll = 0;
    r0 = n_realign;
    underflow_once();
    check(n_realign - r0 == 1, "R10 lock ignored when unqualified", n_realign - r0, 1);

    // R9 pointer reset and recentering
    @(negedge rd_clk); cfg_realign_sel = 0;
    r0 = n_realign; p0 = n_prst;
    underflow_once();
    check(n_prst - p0 == 1, "R9 pointer reset issued", n_prst - p0, 1);
    check(n_realign == r0, "R9 no realign", n_realign - r0, 0);
    @(negedge rd_clk); cfg_auto_recover = 0; stale_mode = 1;
    s0 = n_spill; v0 = n_valid;
    read_cycles(9);
    idle(10);
    stale_mode = 0;
    check(n_valid - v0 == 8, "R9 half depth readable", n_valid - v0, 8);
    check(n_spill - s0 == 1, "R9 spill after recentered drain", n_spill - s0, 1);

    // clear the pending underflow with one good read
    write_burst(1, 1);
    idle(20);
    read_cycles(1);
    idle(10);

    // R2 overflow
    s0 = n_spill; v0 = n_valid;
    write_burst(20, 16);
    idle(20);
    check(n_spill - s0 == 1, "R2 spill on overflow", n_spill - s0, 1);
    check(n_valid == v0, "R2 no reads while filling", n_valid - v0, 0);
    read_cycles(16);
    idle(10);
    check(n_valid - v0 == 16, "R2 exactly depth stored", n_valid - v0, 16);
    check(model_q.size() == 0, "R2 dropped writes absent", model_q.size(), 0);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule